// File: doc/BRIEF.md
# MDIO Management Access Controller

This block lets a host reach PHY registers over a two-wire management link (MDC clock, bidirectional MDIO data). The host sees two registers behind one request/response port. The address register holds a 5-bit PHY address and a 5-bit register address. The data register does not simply store a value: any access to it runs a management transaction. Reading it runs a read frame and returns the 16-bit value the PHY sent. Writing it runs a write frame that carries the written value.

Accesses to PHY address 31 never reach the wire. They are routed to an on-chip PHY register port through a valid/ready handshake, and MDC stays idle. The block generates MDC from the system clock with a divider. It releases MDIO for the read turnaround and the read data, samples read bits when MDC rises, and changes outgoing bits only while MDC is low.

The host request port is valid/ready. A request must hold its valid, write flag, select and data unchanged until it is accepted. Only one access is in flight at a time. A request is not accepted while a frame or internal access is running, or while a response is waiting. The response port is also valid/ready. Once raised, the response stays valid with the same data until the host takes it.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A request with req_sel=0 reaches the address register. A write stores req_wdata[9:5] as the PHY address and req_wdata[4:0] as the register address, and ignores bits 31:10. Every address-register access returns {22'b0, phy, reg} as its response, with no frame and no internal access.
- R2: A write with req_sel=1 stores req_wdata[15:0] as the data value and ignores bits 31:16. It then sends 64 MDC cycles with these bits, first bit first: 32 ones, 01, opcode 01, PHY address MSB first, register address MSB first, turnaround 10, then the 16 data bits MSB first. The response is {16'b0, data}.
- R3: A read with req_sel=1 sends the same preamble, start bits and addresses with opcode 10. MDIO is released (mdio_oe=0) from the first turnaround bit to the end of the frame. The 16 bits present on mdio_i at the MDC rises of bits 48..63 become the data value, MSB first, and the response is {16'b0, value}.
- R4: During a frame, MDC high and low phases each last HALF = ceil(CLK_HZ/(2*MDC_MAX_HZ)) clocks (25 by default, giving 2.5 MHz). MDC and mdio_oe are low whenever busy is low. mdio_o changes only in cycles where MDC is low.
- R5: When the stored PHY address is 31, a data access raises iphy_valid with iphy_wr, iphy_addr = register address and iphy_wdata = data value, and waits for iphy_ready. A read takes iphy_rdata as the new data value. No MDC edge and no MDIO drive occur during such an access.
- R6: busy is high from the cycle after a data access is accepted until it completes. req_ready is low while busy is high or while a response is pending.
- R7: done pulses high for exactly one clock per completed data access, in the cycle the response appears. rsp_valid and rsp_rdata hold steady until rsp_ready is seen.
- R8: Hard reset clears both registers and leaves MDC low, MDIO released, busy, done and rsp_valid low. soft_rst aborts any frame or internal access and any pending response, returns MDC and MDIO to idle, and keeps both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hard reset, active low |
| soft_rst | input | 1 | Synchronous abort, keeps registers |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted when high with valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = address register, 1 = data register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes response |
| rsp_rdata | output | 32 | Response data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |
| iphy_valid | output | 1 | Internal PHY access request |
| iphy_ready | input | 1 | Internal PHY access complete |
| iphy_wr | output | 1 | Internal access is a write |
| iphy_addr | output | 5 | Internal PHY register address |
| iphy_wdata | output | 16 | Internal PHY write data |
| iphy_rdata | input | 16 | Internal PHY read data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
Two events can fall in the same cycle: a frame completing (done pulsing and the response appearing) and a new host request waiting at the request port. The bench holds an address-register request valid for the whole of a write frame. It also keeps rsp_ready low for several cycles after done. It then checks that req_ready stays low through done and the back-pressured response, that the response data stays steady, and that the waiting request is taken only after the response handshake and returns the right address.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam int ADR_W      = 5;
  localparam int RD_RELEASE = 46;   // first released bit index of a read frame
  localparam int DATA_FIRST = 48;   // first data bit index
  localparam logic [ADR_W-1:0] INT_PHY = 5'h1F;

  typedef enum logic [1:0] {ST_IDLE, ST_EXT, ST_INT, ST_RSP} host_st_e;

  function automatic logic [FRAME_BITS-1:0] frame_bits(input logic rd,
      input logic [ADR_W-1:0] phy, input logic [ADR_W-1:0] ra,
      input logic [DATA_BITS-1:0] wd);
    logic [1:0] op, ta;
    logic [DATA_BITS-1:0] dv;
    op = rd ? 2'b10 : 2'b01;
    ta = rd ? 2'b00 : 2'b10;
    dv = rd ? '0 : wd;
    return {32'hFFFF_FFFF, 2'b01, op, phy, ra, ta, dv};
  endfunction

  function automatic logic [FRAME_BITS-1:0] frame_oe(input logic rd);
    logic [FRAME_BITS-1:0] m;
    m = '1;
    if (rd) m = {{RD_RELEASE{1'b1}}, {(FRAME_BITS-RD_RELEASE){1'b0}}};
    return m;
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int HALF    = 25,
  parameter int IN_SYNC = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 abort,
  input  logic                 start,
  input  logic                 op_rd,
  input  logic [ADR_W-1:0]     phy,
  input  logic [ADR_W-1:0]     regad,
  input  logic [DATA_BITS-1:0] wdata,
  input  logic                 mdio_i,
  output logic                 mdc,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 fin,
  output logic [DATA_BITS-1:0] rdata
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] IDX_LAST  = IW'(FRAME_BITS - 1);
  localparam logic [IW-1:0] IDX_DATA  = IW'(DATA_FIRST);

  logic                  running, mdc_q, rd_q, tick, din;
  logic [IW-1:0]         idx;
  logic [FRAME_BITS-1:0] frm_sr, oe_sr;
  logic [DATA_BITS-1:0]  rd_sh;

  generate
    if (IN_SYNC == 0) begin : g_nosync
      assign din = mdio_i;
    end else begin : g_sync
      logic [IN_SYNC-1:0] sy;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy <= '1;
        else        sy <= {sy[IN_SYNC-2:0], mdio_i};
      end
      assign din = sy[IN_SYNC-1];
    end
  endgenerate

  mdio_clk_div #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(running), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      mdc_q   <= 1'b0;
      rd_q    <= 1'b0;
      idx     <= '0;
      frm_sr  <= '0;
      oe_sr   <= '0;
      rd_sh   <= '0;
      fin     <= 1'b0;
    end else if (abort) begin
      running <= 1'b0;
      mdc_q   <= 1'b0;
      oe_sr   <= '0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start && !running) begin
        running <= 1'b1;
        mdc_q   <= 1'b0;
        rd_q    <= op_rd;
        idx     <= '0;
        frm_sr  <= frame_bits(op_rd, phy, regad, wdata);
        oe_sr   <= frame_oe(op_rd);
      end else if (running && tick) begin
        if (!mdc_q) begin
          mdc_q <= 1'b1;
          if (rd_q && idx >= IDX_DATA) rd_sh <= {rd_sh[DATA_BITS-2:0], din};
        end else begin
          mdc_q  <= 1'b0;
          frm_sr <= frm_sr << 1;
          oe_sr  <= oe_sr << 1;
          if (idx == IDX_LAST) begin
            running <= 1'b0;
            fin     <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = frm_sr[FRAME_BITS-1];
  assign mdio_oe = oe_sr[FRAME_BITS-1];
  assign rdata   = rd_sh;
endmodule

// File: rtl/mdio_host_ctrl.sv
module mdio_host_ctrl
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_wr,
  input  logic                 req_sel,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [31:0]          rsp_rdata,
  output logic                 eng_start,
  output logic                 eng_rd,
  output logic [ADR_W-1:0]     eng_phy,
  output logic [ADR_W-1:0]     eng_reg,
  output logic [DATA_BITS-1:0] eng_wdata,
  input  logic                 eng_fin,
  input  logic [DATA_BITS-1:0] eng_rdata,
  output logic                 iphy_valid,
  input  logic                 iphy_ready,
  output logic                 iphy_wr,
  output logic [ADR_W-1:0]     iphy_addr,
  output logic [DATA_BITS-1:0] iphy_wdata,
  input  logic [DATA_BITS-1:0] iphy_rdata,
  output logic                 busy,
  output logic                 done
);
  localparam int AREG_W = 2 * ADR_W;

  host_st_e              st;
  logic [AREG_W-1:0]     addr_q;
  logic [DATA_BITS-1:0]  data_q;
  logic                  rsp_is_addr, op_rd, start_q, accept;
  logic                  unused_hi;

  assign unused_hi = ^req_wdata[31:AREG_W];
  assign req_ready = (st == ST_IDLE) && !soft_rst;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      addr_q      <= '0;
      data_q      <= '0;
      rsp_is_addr <= 1'b0;
      op_rd       <= 1'b0;
      start_q     <= 1'b0;
      done        <= 1'b0;
    end else if (soft_rst) begin
      st      <= ST_IDLE;
      start_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      done    <= 1'b0;
      start_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          if (!req_sel) begin
            rsp_is_addr <= 1'b1;
            if (req_wr) addr_q <= req_wdata[AREG_W-1:0];
            st <= ST_RSP;
          end else begin
            rsp_is_addr <= 1'b0;
            op_rd       <= !req_wr;
            if (req_wr) data_q <= req_wdata[DATA_BITS-1:0];
            if (addr_q[AREG_W-1:ADR_W] == INT_PHY) begin
              st <= ST_INT;
            end else begin
              st      <= ST_EXT;
              start_q <= 1'b1;
            end
          end
        end
        ST_EXT: if (eng_fin) begin
          if (op_rd) data_q <= eng_rdata;
          done <= 1'b1;
          st   <= ST_RSP;
        end
        ST_INT: if (iphy_ready) begin
          if (op_rd) data_q <= iphy_rdata;
          done <= 1'b1;
          st   <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign eng_start  = start_q;
  assign eng_rd     = op_rd;
  assign eng_phy    = addr_q[AREG_W-1:ADR_W];
  assign eng_reg    = addr_q[ADR_W-1:0];
  assign eng_wdata  = data_q;
  assign iphy_valid = (st == ST_INT);
  assign iphy_wr    = !op_rd;
  assign iphy_addr  = addr_q[ADR_W-1:0];
  assign iphy_wdata = data_q;
  assign busy       = (st == ST_EXT) || (st == ST_INT);
  assign rsp_valid  = (st == ST_RSP);
  assign rsp_rdata  = rsp_is_addr ? {{(32-AREG_W){1'b0}}, addr_q}
                                  : {{(32-DATA_BITS){1'b0}}, data_q};
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_HZ     = 125_000_000,
  parameter int MDC_MAX_HZ = 2_500_000,
  parameter int IN_SYNC    = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_wr,
  input  logic        req_sel,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        iphy_valid,
  input  logic        iphy_ready,
  output logic        iphy_wr,
  output logic [4:0]  iphy_addr,
  output logic [15:0] iphy_wdata,
  input  logic [15:0] iphy_rdata,
  output logic        busy,
  output logic        done
);
  localparam int HALF = (CLK_HZ + 2*MDC_MAX_HZ - 1) / (2*MDC_MAX_HZ);

  logic                 eng_start, eng_rd, eng_fin;
  logic [ADR_W-1:0]     eng_phy, eng_reg;
  logic [DATA_BITS-1:0] eng_wdata, eng_rdata;

  mdio_host_ctrl u_host (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .eng_start(eng_start), .eng_rd(eng_rd), .eng_phy(eng_phy),
    .eng_reg(eng_reg), .eng_wdata(eng_wdata), .eng_fin(eng_fin),
    .eng_rdata(eng_rdata),
    .iphy_valid(iphy_valid), .iphy_ready(iphy_ready), .iphy_wr(iphy_wr),
    .iphy_addr(iphy_addr), .iphy_wdata(iphy_wdata), .iphy_rdata(iphy_rdata),
    .busy(busy), .done(done)
  );

  mdio_frame_engine #(.HALF(HALF), .IN_SYNC(IN_SYNC)) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(soft_rst), .start(eng_start),
    .op_rd(eng_rd), .phy(eng_phy), .regad(eng_reg), .wdata(eng_wdata),
    .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .fin(eng_fin), .rdata(eng_rdata)
  );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        iphy_valid,
  input logic        busy,
  input logic        done
);
  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !soft_rst) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_launch_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc);

  assert_idle_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_int_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iphy_valid |-> (!mdc && !mdio_oe));

  assert_soft_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !mdc && !rsp_valid));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .iphy_valid(iphy_valid),
  .busy(busy), .done(done)
);

// File: tb/test_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module test_mdio_mgmt_ctrl;
  localparam int HALF = 25;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0, req_sel = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_wdata = '0;
  logic mdio_i = 1'b1, iphy_ready = 1'b0;
  logic req_ready, rsp_valid, mdc, mdio_o, mdio_oe, iphy_valid, iphy_wr, busy, done;
  logic [31:0] rsp_rdata;
  logic [4:0]  iphy_addr;
  logic [15:0] iphy_wdata, iphy_rdata;

  always #4 clk = ~clk;

  mdio_mgmt_ctrl i_mdio_mgmt_ctrl (.*);

  // internal PHY model: answers one cycle after a request
  assign iphy_rdata = 16'h3C00 | {11'b0, iphy_addr};
  logic [4:0]  ip_last_addr;
  logic [15:0] ip_last_data;
  int          ip_writes = 0;
  always @(negedge clk) begin
    if (iphy_valid && !iphy_ready) begin
      iphy_ready = 1'b1;
      if (iphy_wr) begin ip_last_addr = iphy_addr; ip_last_data = iphy_wdata; ip_writes++; end
    end else iphy_ready = 1'b0;
  end

  // external PHY model and line monitor
  int cyc = 0;
  always @(posedge clk) cyc++;
  logic        mdc_prev = 1'b0, ph_rd = 1'b0;
  logic [15:0] ph_val = '0;
  logic [63:0] cap, oecap;
  int nbits = 0, rises = 0, last_rise = 0, last_fall = 0, hi_len = 0, lo_len = 0, done_cnt = 0;
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (mdc && !mdc_prev) begin
      rises++;
      if (nbits > 0) lo_len = cyc - last_fall;
      if (nbits < 64) begin
        cap[63-nbits]   = mdio_oe ? mdio_o : mdio_i;
        oecap[63-nbits] = mdio_oe;
      end
      nbits++;
      last_rise = cyc;
    end
    if (!mdc && mdc_prev) begin
      hi_len = cyc - last_rise;
      last_fall = cyc;
      if (ph_rd && nbits >= 48 && nbits <= 63) mdio_i = ph_val[63-nbits];
      else mdio_i = 1'b1;
    end
    mdc_prev = mdc;
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic host_op(input logic wr, input logic sel, input logic [31:0] wd,
                         output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_sel = sel; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    @(negedge clk);
  endtask

  function automatic logic [63:0] exp_frame(logic rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, r, rd ? 2'b11 : 2'b10, d};
  endfunction

  // {write, phy, reg, data}
  localparam logic [26:0] VEC [6] = '{
    {1'b1, 5'd1,  5'd0,  16'h1200},
    {1'b0, 5'd1,  5'd1,  16'h796D},
    {1'b1, 5'd0,  5'd31, 16'hFFFF},
    {1'b0, 5'd30, 5'd2,  16'h0000},
    {1'b1, 5'd17, 5'd10, 16'hA5A5},
    {1'b0, 5'd3,  5'd16, 16'h8001}
  };

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R6 act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rv;
    int r0, d0, acc_cyc, done_cyc;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 busy", busy, 0);
    chk("R8 mdc/oe", {mdc, mdio_oe}, 0);
    chk("R8 ready/rsp/done", {req_ready, rsp_valid, done}, 3'b100);
    host_op(1'b0, 1'b0, 0, rv);
    chk("R8 R1 addr reset", rv, 0);

    // vector table
    for (int i = 0; i < 6; i++) begin
      logic wr; logic [4:0] p, r; logic [15:0] d;
      {wr, p, r, d} = VEC[i];
      host_op(1'b1, 1'b0, {22'h3FFFFF, p, r}, rv);
      chk("R1 addr write rsp", rv, {22'b0, p, r});
      host_op(1'b0, 1'b0, 0, rv);
      chk("R1 addr readback", rv, {22'b0, p, r});
      nbits = 0; ph_rd = !wr; ph_val = d; d0 = done_cnt;
      host_op(wr, 1'b1, {16'hDEAD, wr ? d : 16'h0}, rv);
      if (wr) chk("R2 write rsp", rv, {16'b0, d});
      else    chk("R3 read rsp", rv, {16'b0, d});
      chk(wr ? "R2 frame bits" : "R3 frame bits", cap, exp_frame(!wr, p, r, d));
      chk(wr ? "R2 drive mask" : "R3 release mask", oecap,
          wr ? {64{1'b1}} : {{46{1'b1}}, 18'b0});
      chk("R2 R3 bit count", nbits, 64);
      chk("R7 done once", done_cnt - d0, 1);
      chk("R4 mdc high", hi_len, HALF);
      chk("R4 mdc low", lo_len, HALF);
    end

    // R5 internal PHY
    host_op(1'b1, 1'b0, {22'b0, 5'd31, 5'd7}, rv);
    r0 = rises; d0 = done_cnt;
    host_op(1'b1, 1'b1, 32'h0000_4321, rv);
    chk("R5 iphy write", {ip_writes, ip_last_addr, ip_last_data}, {32'd1, 5'd7, 16'h4321});
    chk("R5 write rsp", rv, 32'h4321);
    host_op(1'b0, 1'b1, 0, rv);
    chk("R5 iphy read", rv, 32'h3C07);
    chk("R5 no mdc", rises - r0, 0);
    chk("R7 R5 done count", done_cnt - d0, 2);

    // R6/R7 collision: queued request during frame and back-pressured response
    host_op(1'b1, 1'b0, {22'b0, 5'd4, 5'd9}, rv);
    nbits = 0; ph_rd = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b1; req_sel = 1'b1; req_wdata = 32'h0000_5AA5;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_wr = 1'b0; req_sel = 1'b0; rsp_ready = 1'b0;
    repeat (100) @(negedge clk);
    chk("R6 busy during frame", {busy, req_ready}, 2'b10);
    while (!done) @(negedge clk);
    done_cyc = cyc;
    repeat (5) begin
      @(negedge clk);
      chk("R7 rsp held", {rsp_valid, req_ready, rsp_rdata}, {2'b10, 32'h5AA5});
    end
    rsp_ready = 1'b1;
    while (!req_ready) @(negedge clk);
    acc_cyc = cyc;
    chk("R6 accept after rsp", acc_cyc > done_cyc + 5, 1);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk("R6 queued addr read", rsp_rdata, {22'b0, 5'd4, 5'd9});
    @(negedge clk);

    // R8 soft reset mid-frame
    ph_rd = 1'b1; ph_val = 16'hFFFF; nbits = 0;
    @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b0; req_sel = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (300) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R8 soft abort", {busy, mdc, mdio_oe, rsp_valid}, 0);
    r0 = rises;
    repeat (100) @(negedge clk);
    chk("R8 mdc stays idle", rises - r0, 0);
    host_op(1'b0, 1'b0, 0, rv);
    chk("R8 addr kept", rv, {22'b0, 5'd4, 5'd9});

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule